// File: doc/BRIEF.md
# AC-Driven Seven-Segment LCD Driver

This block turns a latched conversion result into the drive waveforms for a three-and-a-half digit seven-segment liquid crystal display. It divides the master clock to make a square-wave backplane, and every segment line is that backplane either passed through unchanged (segment dark) or inverted (segment visible). The mean voltage across any segment over a full backplane period is therefore zero, which is what the glass needs for a long life.

The result arrives as an unsigned binary number from 0 to 1999, together with a sign flag and an overrange flag. The block converts it to three decimal digits plus a leading half digit that can only show "1", and it lights a minus segment for negative results. New display content is taken only at a backplane transition, so a segment never changes level in the middle of a backplane phase.

Top module: `lcd_seg_drive`

## Requirements
- R1: While reset is high, and on the first clock after it, the backplane is low and every segment output is low.
- R2: The backplane period is DIV master clocks (default 800). It first goes high HALF = DIV/2 clocks after reset is released and then toggles every HALF clocks.
- R3: Each segment output equals the backplane when that segment is dark and its inverse when it is lit.
- R4: The value, sign and overrange inputs are sampled only on the clock edge where the backplane toggles. Input changes at any other time have no effect on the outputs until the next toggle, and no segment output changes except together with the backplane.
- R5: Each full digit drives seven lines with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g. The lit patterns in hex are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. Leading zeros are shown.
- R6: For values 0 to 999 the half digit is dark and the three digits show the value. For values 1000 to 1999 the half digit is lit and the digits show the value minus 1000.
- R7: When the overrange flag is set, or the value exceeds 1999, the half digit is lit and all 21 full-digit segments are dark.
- R8: The minus segment is lit exactly when the sign flag was high at the last sample. This also holds under overrange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| value | input | 11 | Unsigned result, 0 to 1999 |
| neg | input | 1 | Sign flag, high for a negative input |
| ovr | input | 1 | Overrange flag |
| bp | output | 1 | Backplane square wave |
| seg_ones | output | 7 | Units digit segments a..g (bit 0 = a) |
| seg_tens | output | 7 | Tens digit segments |
| seg_hund | output | 7 | Hundreds digit segments |
| seg_half | output | 1 | Leading "1" segment pair |
| seg_minus | output | 1 | Minus sign segment |

## Verification
A divider that counts to the wrong limit shows up as a backplane edge in the wrong cycle, so it is seen at the first toggle, HALF clocks after reset. A wrong latched display word shows up at the next backplane edge, when every segment is compared against a decoded expectation. A latch that also loads between edges shows up within one clock of a mid-phase input change. Because segments are XORed with the backplane, a segment stuck at one polarity differs from the model in one of every two phases, so it is caught within one backplane period.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int VAL_W       = 11;
    localparam int MAX_VAL     = 1999;
    localparam int HALF_OFFSET = 1000;
    localparam int SEG_W       = 7;
    localparam int BP_DIV      = 800;

    typedef logic [SEG_W-1:0] seg7_t;

    typedef struct packed {
        logic  minus;
        logic  half;
        seg7_t hund;
        seg7_t tens;
        seg7_t ones;
    } disp_t;

    localparam int DISP_W = $bits(disp_t);

    // Lit-segment pattern for one decimal digit, bit 0 = segment a.
    function automatic seg7_t digit_to_seg(input logic [3:0] d);
        seg7_t s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    // Lit-segment map for a whole reading.
    function automatic disp_t build_disp(input logic [VAL_W-1:0] v,
                                         input logic             neg,
                                         input logic             ovr);
        disp_t r;
        int    n;
        r       = '0;
        r.minus = neg;
        n       = int'(v);
        if (ovr || n > MAX_VAL) begin
            r.half = 1'b1;
        end else begin
            if (n >= HALF_OFFSET) begin
                r.half = 1'b1;
                n      = n - HALF_OFFSET;
            end
            r.hund = digit_to_seg(4'(n / 100));
            r.tens = digit_to_seg(4'((n / 10) % 10));
            r.ones = digit_to_seg(4'(n % 10));
        end
        return r;
    endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
    parameter int DIV = lcd_drv_pkg::BP_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic bp,
    output logic toggle
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign toggle = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (toggle) begin
            cnt <= '0;
            bp  <= ~bp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The backplane moves only after a full half period of counting.
    assert_bp_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(bp) |-> $past(cnt) == CW'(HALF - 1));

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(HALF - 1));

endmodule

// File: rtl/lcd_frame_latch.sv
module lcd_frame_latch
    import lcd_drv_pkg::*;
#(
    parameter int VW = VAL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [VW-1:0] value,
    input  logic          neg,
    input  logic          ovr,
    output disp_t         disp_q
);
    disp_t disp_d;

    always_comb begin
        disp_d = build_disp(VAL_W'(value), neg, ovr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q <= '0;
        end else if (load) begin
            disp_q <= disp_d;
        end
    end

    // Between backplane edges the displayed content is frozen.
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(disp_q));

    // Overrange blanks all full digits and lights the half digit.
    assert_blank_R7: assert property (@(posedge clk) disable iff (rst)
        (load && ovr) |=> (disp_q.half && disp_q.ones == '0 &&
                           disp_q.tens == '0 && disp_q.hund == '0));

    // The sign is carried regardless of overrange.
    assert_sign_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> disp_q.minus == $past(neg));

endmodule

// File: rtl/lcd_ac_drive.sv
module lcd_ac_drive #(
    parameter int W = lcd_drv_pkg::DISP_W
) (
    input  logic [W-1:0] lit,
    input  logic         bp,
    output logic [W-1:0] drive
);
    // Per-line phase selection: lit lines run opposite to the backplane.
    for (genvar i = 0; i < W; i++) begin : g_line
        assign drive[i] = lit[i] ^ bp;
    end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcd_drv_pkg::*;
#(
    parameter int DIV = BP_DIV,
    parameter int VW  = VAL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] value,
    input  logic          neg,
    input  logic          ovr,
    output logic          bp,
    output logic [6:0]    seg_ones,
    output logic [6:0]    seg_tens,
    output logic [6:0]    seg_hund,
    output logic          seg_half,
    output logic          seg_minus
);
    logic              toggle;
    disp_t             disp_q;
    logic [DISP_W-1:0] drive_bits;
    disp_t             drv;

    lcd_bp_gen #(.DIV(DIV)) u_bp (
        .clk    (clk),
        .rst    (rst),
        .bp     (bp),
        .toggle (toggle)
    );

    lcd_frame_latch #(.VW(VW)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (toggle),
        .value  (value),
        .neg    (neg),
        .ovr    (ovr),
        .disp_q (disp_q)
    );

    lcd_ac_drive #(.W(DISP_W)) u_ac (
        .lit   (disp_q),
        .bp    (bp),
        .drive (drive_bits)
    );

    assign drv       = disp_t'(drive_bits);
    assign seg_ones  = drv.ones;
    assign seg_tens  = drv.tens;
    assign seg_hund  = drv.hund;
    assign seg_half  = drv.half;
    assign seg_minus = drv.minus;

    // Reset leaves the glass with zero drive on backplane and segments.
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!bp && seg_ones == '0 && seg_tens == '0 &&
                 seg_hund == '0 && !seg_half && !seg_minus));

    // No segment line moves unless the backplane moves with it.
    assert_seg_edge_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable({seg_ones, seg_tens, seg_hund, seg_half, seg_minus})
            |-> !$stable(bp));

endmodule

// File: tb/tb_lcd_seg_drive.sv
module tb_lcd_seg_drive;
    localparam int HALF = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] value = '0;
    logic        neg = 1'b0;
    logic        ovr = 1'b0;
    logic        bp;
    logic [6:0]  seg_ones, seg_tens, seg_hund;
    logic        seg_half, seg_minus;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    lcd_seg_drive dut (
        .clk(clk), .rst(rst), .value(value), .neg(neg), .ovr(ovr),
        .bp(bp), .seg_ones(seg_ones), .seg_tens(seg_tens),
        .seg_hund(seg_hund), .seg_half(seg_half), .seg_minus(seg_minus)
    );

    // ---- reference model (behavioural) ----
    function automatic logic [6:0] pat(input int d);
        logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return t[d];
    endfunction

    int         m_cnt = 0;
    logic       m_bp = 0;
    logic [6:0] m_ones = 0, m_tens = 0, m_hund = 0;
    logic       m_half = 0, m_minus = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_bp = 0;
            m_ones = 0; m_tens = 0; m_hund = 0; m_half = 0; m_minus = 0;
        end else if (m_cnt == HALF - 1) begin
            int n;
            m_cnt   = 0;
            m_bp    = ~m_bp;
            m_minus = neg;
            n       = int'(value);
            if (ovr || n > 1999) begin
                m_half = 1; m_ones = 0; m_tens = 0; m_hund = 0;
            end else begin
                m_half = (n >= 1000);
                if (n >= 1000) n -= 1000;
                m_hund = pat(n / 100);
                m_tens = pat((n / 10) % 10);
                m_ones = pat(n % 10);
            end
        end else begin
            m_cnt++;
        end
    end

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model (R2, R3, R5, R6, R7, R8).
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 backplane", {6'b0, bp}, {6'b0, m_bp});
            chk("R5/R6 ones",   seg_ones,  m_ones ^ {7{m_bp}});
            chk("R5/R6 tens",   seg_tens,  m_tens ^ {7{m_bp}});
            chk("R5/R6 hund",   seg_hund,  m_hund ^ {7{m_bp}});
            chk("R6/R7 half",   {6'b0, seg_half},  {6'b0, m_half ^ m_bp});
            chk("R8 minus",     {6'b0, seg_minus}, {6'b0, m_minus ^ m_bp});
        end
    end

    task automatic show(input int v, input bit s, input bit o, input int phases);
        value = 11'(v); neg = s; ovr = o;
        repeat (phases * HALF) @(negedge clk);
    endtask

    initial begin
        logic [6:0] snap;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 bp",   {6'b0, bp}, 7'h0);
        chk("R1 segs", seg_ones | seg_tens | seg_hund | {5'b0, seg_half, seg_minus}, 7'h0);
        @(negedge clk); rst = 0;
        // R2 first rise exactly HALF clocks after release
        value = 11'd8;
        repeat (HALF - 1) @(negedge clk);
        chk("R2 still low before half period", {6'b0, bp}, 7'h0);
        @(negedge clk);
        chk("R2 high at half period", {6'b0, bp}, 7'h1);
        // R5 digit 8 lit pattern while bp high: line = lit ^ 1
        chk("R5 pattern of 8", seg_ones, 7'h7F ^ 7'h7F);
        // R3 dark half digit follows bp
        chk("R3 dark segment equals bp", {6'b0, seg_half}, {6'b0, bp});
        show(123, 0, 0, 3);
        show(1234, 1, 0, 2);
        // R4 mid-phase change ignored
        repeat (100) @(negedge clk);
        snap = seg_ones;
        value = 11'd567; ovr = 1;
        repeat (20) @(negedge clk);
        chk("R4 mid-phase input ignored", seg_ones, snap);
        ovr = 0;
        show(567, 0, 0, 3);
        show(0, 0, 0, 2);
        show(999, 1, 0, 2);
        show(1000, 0, 0, 2);
        show(1999, 0, 0, 2);
        show(2047, 0, 0, 2);
        // R7 overrange blanks digits (lines equal bp)
        chk("R7 clamp blank ones", seg_ones, {7{bp}});
        show(500, 1, 1, 3);
        chk("R7 ovr blank tens", seg_tens, {7{bp}});
        chk("R7 ovr half lit", {6'b0, seg_half}, {6'b0, ~bp});
        chk("R8 minus lit under ovr", {6'b0, seg_minus}, {6'b0, ~bp});
        show(42, 0, 0, 2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        done = 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule